// File: doc/BRIEF.md
# IO Address Translation Table Walker

This block turns the addresses that DMA-capable devices put on the bus into physical memory addresses. It takes one request at a time. Each request carries a 16-bit device number, an IO virtual address and a read/write flag. The block first fetches the device's context entry from a device table held in memory. That entry names a domain and the root of the device's page tables. The block then walks between three and six levels of page table through a single read port with variable latency, and returns either a physical address or a fault with a classified cause.

Permission is checked at every level it passes through. A walk that meets a missing right stops at once, which gives the same result as ANDing the read and write rights across the whole path. A walk may end early on a large-page leaf of 2 MB or 1 GB. Every fault is also pushed into a four-deep fault log that software drains. An interrupt line stays high while the log holds anything. A sticky overflow flag records a fault that found the log full; that fault is dropped.

Top module: `iova_walker`

## Requirements
- R1: The block accepts one request at a time. `req_ready` is high only while idle, and it stays low from acceptance until the response has been taken with `rsp_ready`. `rsp_*` hold steady while `rsp_valid` is high and `rsp_ready` is low.
- R2: The device entry is read at DEV_BASE + devid*8. Its fields are: bit 0 valid, bits 3:1 level count, bits 51:12 root table address, bits 63:52 domain. If valid is 0 or the level count is outside 3..6, the response is a fault with cause 2, and no page-table read follows.
- R3: For a walk of L levels, the first table read is at root + index(L)*8, where index(k) = va[12+9(k-1) +: 9], with bits above bit 63 taken as zero. Each following read uses the next table base and index(k-1). A successful walk ending at level k makes exactly 1 + (L-k+1) memory reads.
- R4: In a page-table entry, bit 0 is present, bit 1 is read right, bit 2 is write right, bit 7 is leaf, and bits 51:12 are the next-table or page base. An entry with bit 0 clear ends the walk with cause 0.
- R5: A read needs bit 1 and a write needs bit 2 at every level visited. A present entry without the needed right ends the walk with cause 1. Not-present takes priority over permission, and permission takes priority over a bad leaf.
- R6: A present entry at level 1, or one with bit 7 set at level 2 or 3, is a leaf. The result is rsp_pa = (base & ~M) | (va & M), where M covers the low 12+9(k-1) bits. Bit 7 set at level 4 or above faults with cause 3.
- R7: Each fault pushes {devid, va, write flag, cause} into a 4-entry log, which is read in arrival order through `flog_*` and popped with `flog_pop`. `irq` is high exactly while the log is not empty.
- R8: A fault that arrives while the log is full and is not being popped is dropped and sets `flog_ovf`. The flag stays set until `flog_ovf_clr` is pulsed.
- R9: `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. Only one memory read is outstanding, and its data is taken on `mem_rsp_valid` whatever the latency.
- R10: A response returns fault = 0 with the physical address and the context's domain on success. A fault returns fault = 1 and rsp_pa = 0. The domain is 0 for a cause 2 fault and the context's domain otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and taking a request |
| req_devid | input | 16 | Requesting device number |
| req_va | input | 64 | IO virtual address |
| req_wr | input | 1 | 1 = write access, 0 = read |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result taken |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | Fault cause (0 not present, 1 permission, 2 bad context, 3 bad leaf) |
| rsp_pa | output | 52 | Physical address |
| rsp_domain | output | 12 | Domain of the context |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory takes read |
| mem_req_addr | output | 52 | Byte address of 8-byte entry |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 64 | Entry contents |
| flog_valid | output | 1 | Fault log has an entry |
| flog_pop | input | 1 | Remove oldest log entry |
| flog_devid | output | 16 | Logged device number |
| flog_va | output | 64 | Logged virtual address |
| flog_wr | output | 1 | Logged access type |
| flog_cause | output | 2 | Logged cause |
| flog_ovf | output | 1 | Sticky overflow flag |
| flog_ovf_clr | input | 1 | Clears the overflow flag |
| irq | output | 1 | Fault interrupt |

## Verification
A wrong level counter or index slice appears on `mem_req_addr` at the first or second table read. It also shows in the response a few cycles later, as a wrong address, an extra read or a spurious not-present fault. A wrong permission or leaf decision comes out as a wrong `rsp_cause` in the very response that caused it. Fault log pointer errors appear on the next `flog_*` read as a lost or reordered entry, or as `irq` disagreeing with the number of entries the bench has pushed.

// File: rtl/iow_pkg.sv
package iow_pkg;
  typedef enum logic [1:0] {
    CAUSE_NOTPRES = 2'd0,
    CAUSE_PERM    = 2'd1,
    CAUSE_CTX     = 2'd2,
    CAUSE_BADENT  = 2'd3
  } cause_e;

  localparam int ENT_W     = 64;
  localparam int ENT_SHIFT = 3;
  localparam int BIT_PRES  = 0;
  localparam int BIT_RD    = 1;
  localparam int BIT_WR    = 2;
  localparam int BIT_LEAF  = 7;
endpackage

// File: rtl/iow_pte_check.sv
module iow_pte_check
  import iow_pkg::*;
#(
  parameter int PA_W         = 52,
  parameter int LVL_W        = 3,
  parameter int PG_SHIFT     = 12,
  parameter int IDX_W        = 9,
  parameter int MAX_LEAF_LVL = 3
) (
  input  logic [ENT_W-1:0] entry,
  input  logic [LVL_W-1:0] lvl,
  input  logic             need_wr,
  input  logic [PA_W-1:0]  va_lo,
  output logic             fault,
  output logic [1:0]       cause,
  output logic             leaf,
  output logic [PA_W-1:0]  next_base,
  output logic [PA_W-1:0]  pa
);
  logic            pres, right_ok, big_leaf, leaf_bad;
  logic [PA_W-1:0] mask;
  int              off;
  logic            unused_bits;

  assign unused_bits = ^{entry[ENT_W-1:PA_W], entry[6:3]};
  assign pres      = entry[BIT_PRES];
  assign right_ok  = need_wr ? entry[BIT_WR] : entry[BIT_RD];
  assign big_leaf  = entry[BIT_LEAF];
  assign leaf_bad  = big_leaf && (lvl > LVL_W'(MAX_LEAF_LVL));
  assign next_base = {entry[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};

  always_comb begin
    off   = PG_SHIFT + IDX_W * (int'(lvl) - 1);
    mask  = (PA_W'(1) << off) - PA_W'(1);
    pa    = (next_base & ~mask) | (va_lo & mask);
    fault = 1'b1;
    leaf  = 1'b0;
    cause = CAUSE_NOTPRES;
    if (!pres) begin
      cause = CAUSE_NOTPRES;
    end else if (!right_ok) begin
      cause = CAUSE_PERM;
    end else if (leaf_bad) begin
      cause = CAUSE_BADENT;
    end else begin
      fault = 1'b0;
      leaf  = (lvl == LVL_W'(1)) || big_leaf;
    end
  end

  always_comb begin
    if (fault) assert (!leaf) else $error("assert_leaf_excl_R6 fault with leaf");
  end
endmodule

// File: rtl/iow_fault_log.sv
module iow_fault_log #(
  parameter int DEPTH   = 4,
  parameter int DEVID_W = 16,
  parameter int VA_W    = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               push,
  input  logic [DEVID_W-1:0] in_devid,
  input  logic [VA_W-1:0]    in_va,
  input  logic               in_wr,
  input  logic [1:0]         in_cause,
  input  logic               pop,
  input  logic               ovf_clr,
  output logic               out_valid,
  output logic [DEVID_W-1:0] out_devid,
  output logic [VA_W-1:0]    out_va,
  output logic               out_wr,
  output logic [1:0]         out_cause,
  output logic               ovf,
  output logic               irq
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DEVID_W-1:0] st_dev   [DEPTH];
  logic [VA_W-1:0]    st_va    [DEPTH];
  logic               st_wr    [DEPTH];
  logic [1:0]         st_cause [DEPTH];
  logic [PTR_W-1:0]   wp, rp;
  logic [CNT_W-1:0]   cnt;
  logic               full, take, drop;

  assign full = (cnt == CNT_W'(DEPTH));
  assign drop = pop && (cnt != '0);
  assign take = push && (!full || drop);

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (take) begin
      st_dev[wp]   <= in_devid;
      st_va[wp]    <= in_va;
      st_wr[wp]    <= in_wr;
      st_cause[wp] <= in_cause;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (take) wp <= bump(wp);
      if (drop) rp <= bump(rp);
      if (take && !drop)      cnt <= cnt + CNT_W'(1);
      else if (drop && !take) cnt <= cnt - CNT_W'(1);
      if (push && full && !drop) ovf <= 1'b1;
      else if (ovf_clr)          ovf <= 1'b0;
    end
  end

  assign out_valid = (cnt != '0);
  assign out_devid = st_dev[rp];
  assign out_va    = st_va[rp];
  assign out_wr    = st_wr[rp];
  assign out_cause = st_cause[rp];
  assign irq       = out_valid;

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf && !ovf_clr |=> ovf);
  assert_full_push_R8: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop |=> ovf);
  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DEPTH));
endmodule

// File: rtl/iow_walk_ctrl.sv
module iow_walk_ctrl
  import iow_pkg::*;
#(
  parameter int              DEVID_W  = 16,
  parameter int              VA_W     = 64,
  parameter int              PA_W     = 52,
  parameter int              LVL_W    = 3,
  parameter int              PG_SHIFT = 12,
  parameter int              IDX_W    = 9,
  parameter int              MIN_LVL  = 3,
  parameter int              MAX_LVL  = 6,
  parameter logic [PA_W-1:0] DEV_BASE = 52'h4000_0000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [DEVID_W-1:0] req_devid,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_wr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [PA_W-1:0]    rsp_pa,
  output logic [ENT_W-PA_W-1:0] rsp_domain,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENT_W-1:0]   mem_rsp_data,
  output logic [LVL_W-1:0]   cur_lvl,
  output logic               cur_wr,
  output logic [VA_W-1:0]    cur_va,
  output logic [DEVID_W-1:0] cur_devid,
  input  logic               chk_fault,
  input  logic [1:0]         chk_cause,
  input  logic               chk_leaf,
  input  logic [PA_W-1:0]    chk_next,
  input  logic [PA_W-1:0]    chk_pa,
  output logic               log_push,
  output logic [1:0]         log_cause
);
  localparam int DOM_W  = ENT_W - PA_W;
  localparam int VA_EXT = PG_SHIFT + IDX_W * MAX_LVL;

  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_PREQ, S_PWAIT, S_RESP} st_e;
  st_e st;

  logic [PA_W-1:0]  addr_q;
  logic             ctx_ok;
  logic [LVL_W-1:0] ctx_lvl;
  logic [PA_W-1:0]  ctx_root;
  logic [DOM_W-1:0] ctx_dom;
  logic             unused_ctx;

  function automatic logic [PA_W-1:0] ent_addr(input logic [PA_W-1:0] base,
                                               input logic [LVL_W-1:0] lvl,
                                               input logic [VA_W-1:0] va);
    logic [VA_EXT-1:0] vx;
    logic [IDX_W-1:0]  idx;
    int                sh;
    vx = '0;
    vx[VA_W-1:0] = va;
    sh  = PG_SHIFT + IDX_W * ((lvl == '0) ? 0 : int'(lvl) - 1);
    idx = vx[sh +: IDX_W];
    return base + (PA_W'(idx) << ENT_SHIFT);
  endfunction

  assign unused_ctx = ^mem_rsp_data[PG_SHIFT-1:LVL_W+1];
  assign ctx_lvl  = mem_rsp_data[LVL_W:1];
  assign ctx_root = {mem_rsp_data[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  assign ctx_dom  = mem_rsp_data[ENT_W-1:PA_W];
  assign ctx_ok   = mem_rsp_data[0] && (ctx_lvl >= LVL_W'(MIN_LVL)) &&
                    (ctx_lvl <= LVL_W'(MAX_LVL));

  assign req_ready     = (st == S_IDLE);
  assign rsp_valid     = (st == S_RESP);
  assign mem_req_valid = (st == S_DREQ) || (st == S_PREQ);
  assign mem_req_addr  = addr_q;

  always_comb begin
    log_push  = 1'b0;
    log_cause = chk_cause;
    if (st == S_DWAIT && mem_rsp_valid && !ctx_ok) begin
      log_push  = 1'b1;
      log_cause = CAUSE_CTX;
    end else if (st == S_PWAIT && mem_rsp_valid && chk_fault) begin
      log_push  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      addr_q     <= '0;
      cur_lvl    <= '0;
      cur_wr     <= 1'b0;
      cur_va     <= '0;
      cur_devid  <= '0;
      rsp_fault  <= 1'b0;
      rsp_cause  <= '0;
      rsp_pa     <= '0;
      rsp_domain <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          cur_devid <= req_devid;
          cur_va    <= req_va;
          cur_wr    <= req_wr;
          addr_q    <= DEV_BASE + (PA_W'(req_devid) << ENT_SHIFT);
          st        <= S_DREQ;
        end
        S_DREQ: if (mem_req_ready) st <= S_DWAIT;
        S_DWAIT: if (mem_rsp_valid) begin
          if (!ctx_ok) begin
            rsp_fault  <= 1'b1;
            rsp_cause  <= CAUSE_CTX;
            rsp_pa     <= '0;
            rsp_domain <= '0;
            st         <= S_RESP;
          end else begin
            cur_lvl    <= ctx_lvl;
            rsp_domain <= ctx_dom;
            addr_q     <= ent_addr(ctx_root, ctx_lvl, cur_va);
            st         <= S_PREQ;
          end
        end
        S_PREQ: if (mem_req_ready) st <= S_PWAIT;
        S_PWAIT: if (mem_rsp_valid) begin
          if (chk_fault) begin
            rsp_fault <= 1'b1;
            rsp_cause <= chk_cause;
            rsp_pa    <= '0;
            st        <= S_RESP;
          end else if (chk_leaf) begin
            rsp_fault <= 1'b0;
            rsp_cause <= '0;
            rsp_pa    <= chk_pa;
            st        <= S_RESP;
          end else begin
            cur_lvl <= cur_lvl - LVL_W'(1);
            addr_q  <= ent_addr(chk_next, cur_lvl - LVL_W'(1), cur_va);
            st      <= S_PREQ;
          end
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_memreq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
  assert_rsp_hold_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_fault, rsp_cause, rsp_pa, rsp_domain}));
  assert_busy_R1: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready);
  assert_fault_pa_R10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_fault |-> rsp_pa == '0);
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import iow_pkg::*;
#(
  parameter int              DEVID_W      = 16,
  parameter int              VA_W         = 64,
  parameter int              PA_W         = 52,
  parameter int              PG_SHIFT     = 12,
  parameter int              IDX_W        = 9,
  parameter int              MIN_LVL      = 3,
  parameter int              MAX_LVL      = 6,
  parameter int              MAX_LEAF_LVL = 3,
  parameter int              LOG_DEPTH    = 4,
  parameter logic [PA_W-1:0] DEV_BASE     = 52'h4000_0000,
  localparam int             LVL_W        = $clog2(MAX_LVL + 1),
  localparam int             DOM_W        = ENT_W - PA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [DEVID_W-1:0] req_devid,
  input  logic [VA_W-1:0]    req_va,
  input  logic               req_wr,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic               rsp_fault,
  output logic [1:0]         rsp_cause,
  output logic [PA_W-1:0]    rsp_pa,
  output logic [DOM_W-1:0]   rsp_domain,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [PA_W-1:0]    mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENT_W-1:0]   mem_rsp_data,
  output logic               flog_valid,
  input  logic               flog_pop,
  output logic [DEVID_W-1:0] flog_devid,
  output logic [VA_W-1:0]    flog_va,
  output logic               flog_wr,
  output logic [1:0]         flog_cause,
  output logic               flog_ovf,
  input  logic               flog_ovf_clr,
  output logic               irq
);
  logic [LVL_W-1:0]   cur_lvl;
  logic               cur_wr;
  logic [VA_W-1:0]    cur_va;
  logic [DEVID_W-1:0] cur_devid;
  logic               chk_fault, chk_leaf, log_push;
  logic [1:0]         chk_cause, log_cause;
  logic [PA_W-1:0]    chk_next, chk_pa;

  iow_walk_ctrl #(
    .DEVID_W(DEVID_W), .VA_W(VA_W), .PA_W(PA_W), .LVL_W(LVL_W),
    .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W), .MIN_LVL(MIN_LVL),
    .MAX_LVL(MAX_LVL), .DEV_BASE(DEV_BASE)
  ) u_ctrl (
    .clk, .rst, .req_valid, .req_ready, .req_devid, .req_va, .req_wr,
    .rsp_valid, .rsp_ready, .rsp_fault, .rsp_cause, .rsp_pa, .rsp_domain,
    .mem_req_valid, .mem_req_ready, .mem_req_addr, .mem_rsp_valid, .mem_rsp_data,
    .cur_lvl, .cur_wr, .cur_va, .cur_devid,
    .chk_fault, .chk_cause, .chk_leaf, .chk_next, .chk_pa,
    .log_push, .log_cause
  );

  iow_pte_check #(
    .PA_W(PA_W), .LVL_W(LVL_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W),
    .MAX_LEAF_LVL(MAX_LEAF_LVL)
  ) u_check (
    .entry(mem_rsp_data), .lvl(cur_lvl), .need_wr(cur_wr),
    .va_lo(cur_va[PA_W-1:0]),
    .fault(chk_fault), .cause(chk_cause), .leaf(chk_leaf),
    .next_base(chk_next), .pa(chk_pa)
  );

  iow_fault_log #(
    .DEPTH(LOG_DEPTH), .DEVID_W(DEVID_W), .VA_W(VA_W)
  ) u_log (
    .clk, .rst, .push(log_push), .in_devid(cur_devid), .in_va(cur_va),
    .in_wr(cur_wr), .in_cause(log_cause), .pop(flog_pop), .ovf_clr(flog_ovf_clr),
    .out_valid(flog_valid), .out_devid(flog_devid), .out_va(flog_va),
    .out_wr(flog_wr), .out_cause(flog_cause), .ovf(flog_ovf), .irq(irq)
  );
endmodule

// File: tb/tb_iova_walker.sv
`timescale 1ns/1ps
module tb_iova_walker;
  localparam logic [51:0] DEVB = 52'h4000_0000;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic req_valid = 0, req_ready, req_wr = 0, rsp_valid, rsp_ready = 0, rsp_fault;
  logic [15:0] req_devid = 0, flog_devid;
  logic [63:0] req_va = 0, flog_va, mrsp_data;
  logic [1:0] rsp_cause, flog_cause;
  logic [51:0] rsp_pa, mreq_addr;
  logic [11:0] rsp_domain;
  logic mreq_valid, mreq_ready, mrsp_valid, flog_valid, flog_pop = 0, flog_wr, flog_ovf;
  logic flog_ovf_clr = 0, irq;

  iova_walker dut (
    .clk, .rst, .req_valid, .req_ready, .req_devid, .req_va, .req_wr,
    .rsp_valid, .rsp_ready, .rsp_fault, .rsp_cause, .rsp_pa, .rsp_domain,
    .mem_req_valid(mreq_valid), .mem_req_ready(mreq_ready), .mem_req_addr(mreq_addr),
    .mem_rsp_valid(mrsp_valid), .mem_rsp_data(mrsp_data),
    .flog_valid, .flog_pop, .flog_devid, .flog_va, .flog_wr, .flog_cause,
    .flog_ovf, .flog_ovf_clr, .irq
  );

  logic [63:0] mem [logic [51:0]];
  int reads = 0, tests = 0, fails = 0;
  logic [51:0] next_tbl = 52'h10_0000;
  bit done = 0;

  function automatic logic [63:0] rd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  // memory with random ready and 1..3 cycles of read latency
  logic pend = 0;
  logic [51:0] paddr;
  int pcnt;
  always @(posedge clk) begin
    mrsp_valid <= 1'b0;
    if (rst) begin
      pend <= 0; mreq_ready <= 0;
    end else if (pend) begin
      if (pcnt == 0) begin mrsp_valid <= 1'b1; mrsp_data <= rd(paddr); pend <= 0; end
      else pcnt <= pcnt - 1;
    end else if (mreq_valid && mreq_ready) begin
      pend <= 1; paddr <= mreq_addr; pcnt <= int'($urandom % 3); reads <= reads + 1;
      mreq_ready <= 0;
    end else mreq_ready <= ($urandom % 4) != 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [8:0] vidx(input logic [63:0] va, input int k);
    logic [65:0] vx;
    vx = {2'b00, va};
    return vx[12 + 9*(k-1) +: 9];
  endfunction

  // reference walk written from the requirements
  task automatic model(input logic [15:0] dev, input logic [63:0] va, input bit wr,
                       output bit f, output logic [1:0] c, output logic [51:0] pa,
                       output logic [11:0] dom, output int nr);
    logic [63:0] e, d;
    logic [51:0] base, mask;
    int L;
    d = rd(DEVB + {33'b0, dev, 3'b000});
    nr = 1; f = 1; pa = 0; dom = 0; c = 2;
    L = int'(d[3:1]);
    if (!d[0] || L < 3 || L > 6) return;
    dom = d[63:52];
    base = {d[51:12], 12'h0};
    for (int k = L; k >= 1; k--) begin
      e = rd(base + {43'b0, vidx(va, k)} * 8);
      nr++;
      if (!e[0]) begin c = 0; return; end
      if (!(wr ? e[2] : e[1])) begin c = 1; return; end
      if (e[7] && k > 3) begin c = 3; return; end
      base = {e[51:12], 12'h0};
      if (k == 1 || e[7]) begin
        mask = (52'd1 << (12 + 9*(k-1))) - 52'd1;
        pa = (base & ~mask) | (va[51:0] & mask);
        f = 0; c = 0;
        return;
      end
    end
  endtask

  task automatic set_dev(input logic [15:0] dev, input bit v, input int L, input logic [11:0] dom);
    logic [51:0] root;
    root = next_tbl; next_tbl += 52'h1000;
    mem[DEVB + {33'b0, dev, 3'b000}] = {dom, root[51:12], 8'h0, 3'(L), v};
  endtask

  // map va at leaf level lf; mid = rights on new table entries, lr = leaf rights
  task automatic build(input logic [15:0] dev, input logic [63:0] va, input int lf,
                       input logic [1:0] mid, input logic [1:0] lr, input logic [51:0] pg);
    logic [63:0] d, e;
    logic [51:0] base, a;
    int L;
    d = rd(DEVB + {33'b0, dev, 3'b000});
    L = int'(d[3:1]);
    base = {d[51:12], 12'h0};
    for (int k = L; k > lf; k--) begin
      a = base + {43'b0, vidx(va, k)} * 8;
      e = rd(a);
      if (e[0] && !e[7]) base = {e[51:12], 12'h0};
      else begin
        mem[a] = {12'h0, next_tbl[51:12], 9'h0, mid, 1'b1};
        base = next_tbl; next_tbl += 52'h1000;
      end
    end
    a = base + {43'b0, vidx(va, lf)} * 8;
    mem[a] = {12'h0, pg[51:12], 4'h0, lf > 1, 4'h0, lr, 1'b1};
  endtask

  bit autopop = 1;
  task automatic run(input logic [15:0] dev, input logic [63:0] va, input bit wr, input string tag);
    bit ef; logic [1:0] ec; logic [51:0] ep; logic [11:0] ed; int en, r0;
    model(dev, va, wr, ef, ec, ep, ed, en);
    r0 = reads;
    @(negedge clk);
    req_valid = 1; req_devid = dev; req_va = va; req_wr = wr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, {tag, " R1 busy"}, 64'(req_ready), 64'h0);
    while (!rsp_valid) @(negedge clk);
    chk(rsp_fault == ef && rsp_cause == ec, {tag, " R5 fault/cause"},
        {61'h0, rsp_fault, rsp_cause}, {61'h0, ef, ec});
    chk(rsp_pa == ep, {tag, " R6 pa"}, 64'(rsp_pa), 64'(ep));
    chk(rsp_domain == ed, {tag, " R10 domain"}, 64'(rsp_domain), 64'(ed));
    chk(reads - r0 == en, {tag, " R3 read count"}, 64'(reads - r0), 64'(en));
    if (ef && autopop) begin
      chk(flog_valid && irq && flog_devid == dev && flog_va == va && flog_wr == wr &&
          flog_cause == ec, {tag, " R7 log head"}, {flog_devid, flog_cause, 45'h0, flog_wr},
          {dev, ec, 45'h0, wr});
    end
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    if (ef && autopop) begin
      flog_pop = 1; @(negedge clk); flog_pop = 0;
    end
  endtask

  logic [15:0] goods [4] = '{16'h0010, 16'h0123, 16'h0ABC, 16'hFFFF};
  logic [63:0] last_va [4];

  initial begin
    void'($urandom(32'h5eed_1234));
    set_dev(16'h0010, 1, 3, 12'h101);
    set_dev(16'h0123, 1, 4, 12'h202);
    set_dev(16'h0ABC, 1, 5, 12'h303);
    set_dev(16'hFFFF, 1, 6, 12'hFFF);
    set_dev(16'h0042, 0, 4, 12'h444);
    set_dev(16'h0043, 1, 7, 12'h555);
    set_dev(16'h0044, 1, 2, 12'h666);
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mreq_valid && !irq && !flog_ovf && !flog_valid,
        "R1 reset state", {59'h0, req_ready, rsp_valid, mreq_valid, irq, flog_ovf}, 64'h10);

    // R2: bad contexts, single read
    run(16'h0042, 64'h1234_5000, 0, "R2 invalid ctx");
    run(16'h0043, 64'h1234_5000, 1, "R2 level 7");
    run(16'h0044, 64'h1234_5000, 0, "R2 level 2");
    // R4: unmapped
    run(16'h0123, 64'h0000_7777_0000, 0, "R4 not present");
    // R6: 4 KB, 2 MB, 1 GB leaves
    build(16'h0123, 64'h0000_1234_5678_9000, 1, 2'b11, 2'b11, 52'hABCDE_F000);
    run(16'h0123, 64'h0000_1234_5678_9ABC, 1, "R6 4k");
    build(16'h0ABC, 64'h0000_0040_0020_0000, 2, 2'b11, 2'b01, 52'h8_0060_0000);
    run(16'h0ABC, 64'h0000_0040_002F_1234, 0, "R6 2M");
    run(16'h0ABC, 64'h0000_0040_002F_1234, 1, "R5 2M write denied");
    build(16'hFFFF, 64'hFF00_0000_4000_0000, 3, 2'b11, 2'b11, 52'h7_C000_0000);
    run(16'hFFFF, 64'hFF00_0000_7FFF_FFF8, 1, "R6 1G six levels");
    // R5: middle level read only, write fails even though leaf allows
    build(16'h0010, 64'h0000_0000_8000_3000, 1, 2'b01, 2'b11, 52'h1_2345_6000);
    run(16'h0010, 64'h0000_0000_8000_3010, 0, "R5 read ok");
    run(16'h0010, 64'h0000_0000_8000_3010, 1, "R5 mid denies write");
    // R6: leaf bit at level 4
    mem[DEVB + 52'h0ABC*8] = mem[DEVB + 52'h0ABC*8];
    build(16'h0ABC, 64'h0000_0F00_0000_0000, 4, 2'b11, 2'b11, 52'h0);
    run(16'h0ABC, 64'h0000_0F00_0000_0000, 0, "R6 bad large leaf");

    // R7/R8: overflow
    autopop = 0;
    for (int i = 0; i < 5; i++) begin
      run(16'h0042, 64'(i), i[0], "R7 fill");
      if (i == 3) chk(!flog_ovf && irq, "R8 no ovf at four", 64'(flog_ovf), 64'h0);
    end
    chk(flog_ovf == 1, "R8 ovf set", 64'(flog_ovf), 64'h1);
    for (int i = 0; i < 4; i++) begin
      chk(flog_valid && flog_va == 64'(i) && flog_cause == 2'd2 && flog_wr == i[0],
          "R7 order", flog_va, 64'(i));
      flog_pop = 1; @(negedge clk); flog_pop = 0;
    end
    chk(!flog_valid && !irq, "R8 fifth dropped", {62'h0, flog_valid, irq}, 64'h0);
    chk(flog_ovf == 1, "R8 sticky", 64'(flog_ovf), 64'h1);
    flog_ovf_clr = 1; @(negedge clk); flog_ovf_clr = 0;
    chk(flog_ovf == 0, "R8 cleared", 64'(flog_ovf), 64'h0);
    autopop = 1;

    // random mix, R9 exercised by the random memory latency
    for (int n = 0; n < 250; n++) begin
      int di, lf, sel;
      logic [63:0] va;
      di = int'($urandom % 4);
      sel = int'($urandom % 4);
      if (sel < 2 || last_va[di] == 0) begin
        va = {$urandom, $urandom};
        lf = 1 + int'($urandom % 3);
        build(goods[di], va, lf, ($urandom % 6 == 0) ? 2'(1 + $urandom % 2) : 2'b11,
              2'($urandom), {$urandom, $urandom} & 52'hF_FFFF_FFFF_F000);
        last_va[di] = va;
      end else if (sel == 2) begin
        va = last_va[di] ^ (64'd1 << ($urandom % 40));
      end else va = {$urandom, $urandom};
      run(goods[di], va, 1'($urandom), "R3 random");
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule